// File: doc/BRIEF.md
# SPI Event Interrupt and Soft-Reset Block

This block sits beside an SPI master core and turns the core's six event lines into one interrupt request. Each event latches into a sticky status bit. A per-source enable mask and a single global enable then gate the status bits onto the interrupt line. Software clears status bits by writing ones back to them.

The same register port also carries a keyed soft reset. Only an exact key word starts a fixed-length reset pulse to the SPI core. The reset clears the status and enable state and leaves the global enable alone. The register port is a plain single-cycle write strobe with an address and a combinational read.

Top module: `spi_irq_ctrl`

## Requirements
- R1: A high cycle on `evt_i[k]` sets status bit k. The bit stays set until it is cleared, even while source k is masked. Bit assignments: 0 mode fault, 1 slave-mode fault, 2 transmit FIFO empty, 3 transmit underrun, 4 receive FIFO full, 5 receive overrun. Status reads at address 0 in bits [5:0].
- R2: A write to address 0 clears every status bit whose position is one in the write data. Status bits whose position is zero in the write data keep their value.
- R3: If a source event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: Bits [5:0] of a write to address 1 replace the per-source enable mask, which reads back at address 1. Writing zero masks every source.
- R5: Bit 31 of a write to address 2 sets the global enable, which reads back in bit 31 of address 2. While it is zero, `irq_o` stays low.
- R6: `irq_o` is high exactly when the global enable is set and some status bit is set together with its enable bit. It follows register state, so it rises one cycle after the event or write that causes it.
- R7: Writing exactly 0x0000000A to address 3 drives `core_rst_o` high for RST_LEN cycles (default 4), starting in the cycle after the write. Address 3 reads as zero.
- R8: A write of any other value to address 3 produces no reset pulse and leaves all register contents unchanged.
- R9: A key write clears the status and enable registers. Both stay clear, ignoring events and writes, while `core_rst_o` is high. The global enable is kept.
- R10: After `rst_ni` is released, all registers read zero and both `irq_o` and `core_rst_o` are low.
- R11: A key write made while the pulse is active restarts the pulse, which then lasts RST_LEN cycles from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses or levels from the SPI core |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |
| core_rst_o | output | 1 | Soft reset pulse to the SPI core |

## Verification
The hardest cases to reach are two collisions. One is an event landing on a status bit in the same cycle that software writes a one to clear it. The other is a second key write arriving while the reset pulse is still counting down, while events keep trying to set status. Directed steps build both collisions on purpose. A long random run then issues the key write rarely, so pulses overlap with random events, clear writes and mask changes. Every cycle is compared against a bench model built from the requirements.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_SRC = 6;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam logic [DATA_W-1:0] RST_KEY = 32'h0000_000A;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_GLOBAL = 2'd2,
    ADDR_RESET  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_clr_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  output logic [N-1:0] status_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          status_o[k] <= 1'b0;
      else if (soft_clr_i)  status_o[k] <= 1'b0;
      else if (set_i[k])    status_o[k] <= 1'b1;  // set beats clear
      else if (w1c_i[k])    status_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int N  = 6,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_clr_i,
  input  logic          en_we_i,
  input  logic          gie_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  enable_o,
  output logic          gie_o
);
  localparam int GIE_BIT = DW - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         enable_o <= '0;
    else if (soft_clr_i) enable_o <= '0;
    else if (en_we_i)    enable_o <= wdata_i[N-1:0];
  end

  // global enable survives soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gie_o <= 1'b0;
    else if (gie_we_i) gie_o <= wdata_i[GIE_BIT];
  end
endmodule

// File: rtl/soft_rst_gen.sv
module soft_rst_gen #(
  parameter int              LEN = 4,
  parameter int              DW  = 32,
  parameter logic [DW-1:0]   KEY = 32'h0000_000A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pulse_o,
  output logic          soft_clr_o
);
  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             key_hit;

  assign key_hit = wr_i && (wdata_i == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (key_hit)       cnt_q <= LEN_C;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o    = (cnt_q != '0);
  assign soft_clr_o = key_hit || pulse_o;
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int NUM_SRC_P = NUM_SRC,
  parameter int DATA_W_P  = DATA_W,
  parameter int RST_LEN   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC_P-1:0]  evt_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W_P-1:0]   wdata_i,
  output logic [DATA_W_P-1:0]   rdata_o,
  output logic                  irq_o,
  output logic                  core_rst_o
);
  localparam int GIE_BIT = DATA_W_P - 1;
  localparam logic [DATA_W_P-1:0] KEY_W = DATA_W_P'(RST_KEY);

  logic [NUM_SRC_P-1:0] status_q, enable_q, w1c;
  logic gie_q, soft_clr;
  logic wr_status, wr_enable, wr_global, wr_reset;

  assign wr_status = we_i && (addr_i == ADDR_STATUS);
  assign wr_enable = we_i && (addr_i == ADDR_ENABLE);
  assign wr_global = we_i && (addr_i == ADDR_GLOBAL);
  assign wr_reset  = we_i && (addr_i == ADDR_RESET);
  assign w1c       = wr_status ? wdata_i[NUM_SRC_P-1:0] : '0;

  irq_status_reg #(.N(NUM_SRC_P)) u_status (
    .clk_i, .rst_ni,
    .soft_clr_i (soft_clr),
    .set_i      (evt_i),
    .w1c_i      (w1c),
    .status_o   (status_q)
  );

  irq_cfg_reg #(.N(NUM_SRC_P), .DW(DATA_W_P)) u_cfg (
    .clk_i, .rst_ni,
    .soft_clr_i (soft_clr),
    .en_we_i    (wr_enable),
    .gie_we_i   (wr_global),
    .wdata_i    (wdata_i),
    .enable_o   (enable_q),
    .gie_o      (gie_q)
  );

  soft_rst_gen #(.LEN(RST_LEN), .DW(DATA_W_P), .KEY(KEY_W)) u_rst (
    .clk_i, .rst_ni,
    .wr_i       (wr_reset),
    .wdata_i    (wdata_i),
    .pulse_o    (core_rst_o),
    .soft_clr_o (soft_clr)
  );

  assign irq_o = gie_q && |(status_q & enable_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_STATUS: rdata_o[NUM_SRC_P-1:0] = status_q;
      ADDR_ENABLE: rdata_o[NUM_SRC_P-1:0] = enable_q;
      ADDR_GLOBAL: rdata_o[GIE_BIT]       = gie_q;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
  parameter int N  = 6,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  evt_i,
  input logic          we_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          irq_o,
  input logic          core_rst_o,
  input logic [N-1:0]  status_q,
  input logic [N-1:0]  enable_q,
  input logic          gie_q,
  input logic          soft_clr
);
  logic key_wr, w1c_wr;
  assign key_wr = we_i && (addr_i == 2'd3) && (wdata_i == DW'(32'h0000_000A));
  assign w1c_wr = we_i && (addr_i == 2'd0);

  assert_latch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i && !soft_clr) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  assert_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_wr && evt_i == '0 && !soft_clr) |=>
      (status_q == ($past(status_q) & ~$past(wdata_i[N-1:0]))));

  assert_gie_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !irq_o);

  assert_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & enable_q) == '0) |-> !irq_o);

  assert_pulse_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(key_wr));

  assert_bad_key_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd3 && !key_wr && !core_rst_o) |=> !core_rst_o);

  assert_soft_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr |=> (core_rst_o && status_q == '0 && enable_q == '0));
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.N(NUM_SRC_P), .DW(DATA_W_P)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .core_rst_o (core_rst_o),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .gie_q      (gie_q),
  .soft_clr   (soft_clr)
);

// File: tb/test_spi_irq_ctrl.sv
`timescale 1ns/1ps
module test_spi_irq_ctrl;
  localparam int N = 6;
  localparam int RST_LEN = 4;
  localparam logic [31:0] KEY = 32'h0000_000A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic irq_o, core_rst_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [N-1:0] m_st = '0, m_en = '0;
  logic m_gie = 1'b0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  spi_irq_ctrl #(.RST_LEN(RST_LEN)) i_spi_irq_ctrl (
    .clk_i(clk), .rst_ni, .evt_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .core_rst_o
  );

  function automatic logic exp_irq();
    return m_gie && |(m_st & m_en);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {26'b0, m_st};
      2'd1: return {26'b0, m_en};
      2'd2: return {m_gie, 31'b0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic [N-1:0] e, input logic w, input logic [1:0] a,
                       input logic [31:0] d);
    logic key, clr;
    key = w && a == 2'd3 && d == KEY;
    clr = key || m_cnt != 0;
    if (w && a == 2'd2) m_gie = d[31];
    if (clr) begin
      m_st = '0; m_en = '0;
    end else begin
      m_st = (m_st & ~((w && a == 2'd0) ? d[N-1:0] : '0)) | e;
      if (w && a == 2'd1) m_en = d[N-1:0];
    end
    if (key) m_cnt = RST_LEN;
    else if (m_cnt != 0) m_cnt--;
  endtask

  task automatic step(input logic [N-1:0] e, input logic w, input logic [1:0] a,
                      input logic [31:0] d);
    @(negedge clk);
    evt_i = e; we_i = w; addr_i = a; wdata_i = d;
    model(e, w, a, d);
    @(posedge clk); #1;
    chk({31'b0, irq_o}, {31'b0, exp_irq()}, "R6 irq");
    chk({31'b0, core_rst_o}, {31'b0, logic'(m_cnt != 0)}, "R7 core_rst");
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step('0, 1'b0, a, '0);
    chk(rdata_o, exp_rd(a), tag);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    chk({30'b0, irq_o, core_rst_o}, 32'h0, "R10 outputs after reset");
    for (int a = 0; a < 4; a++) rd(2'(a), "R10 reset read");

    // R1: latch while masked
    step(6'h01, 1'b0, 2'd0, '0);
    rd(2'd0, "R1 status bit0");
    step(6'h20, 1'b0, 2'd0, '0);
    rd(2'd0, "R1 status bit5 sticky");
    chk({31'b0, irq_o}, 32'h0, "R1 masked no irq");
    // R4/R5/R6
    step('0, 1'b1, 2'd1, 32'h0000_0001);
    rd(2'd1, "R4 enable readback");
    step('0, 1'b1, 2'd2, 32'h8000_0000);
    rd(2'd2, "R5 global readback");
    chk({31'b0, irq_o}, 32'h1, "R6 irq asserted");
    step('0, 1'b1, 2'd2, 32'h7fff_ffff);
    chk({31'b0, irq_o}, 32'h0, "R5 global off blocks irq");
    step('0, 1'b1, 2'd2, 32'h8000_0000);
    // R2: clear bit0 only
    step('0, 1'b1, 2'd0, 32'h0000_0001);
    rd(2'd0, "R2 w1c bit0");
    // R3: set beats clear
    step(6'h20, 1'b1, 2'd0, 32'h0000_0020);
    rd(2'd0, "R3 set wins");
    step(6'h04, 1'b1, 2'd1, 32'h0000_003f);
    chk({31'b0, irq_o}, 32'h1, "R6 irq via bit2");
    step('0, 1'b1, 2'd1, 32'h0);
    chk({31'b0, irq_o}, 32'h0, "R4 zero enable masks all");
    step('0, 1'b1, 2'd1, 32'h0000_0024);
    // R8: wrong keys
    step('0, 1'b1, 2'd3, 32'h0000_000B);
    chk({31'b0, core_rst_o}, 32'h0, "R8 no pulse 0x0B");
    step('0, 1'b1, 2'd3, 32'h0000_010A);
    chk({31'b0, core_rst_o}, 32'h0, "R8 no pulse 0x10A");
    rd(2'd0, "R8 status kept");
    rd(2'd1, "R8 enable kept");
    // R7/R9: key, events during pulse ignored
    step('0, 1'b1, 2'd3, KEY);
    chk({31'b0, core_rst_o}, 32'h1, "R7 pulse start");
    step(6'h3f, 1'b1, 2'd1, 32'h3f);
    rd(2'd0, "R9 status held clear");
    rd(2'd1, "R9 enable held clear");
    rd(2'd2, "R9 global kept");
    rd(2'd3, "R7 reset reads zero");
    chk({31'b0, core_rst_o}, 32'h0, "R7 pulse length");
    // R11: retrigger
    step('0, 1'b1, 2'd3, KEY);
    step('0, 1'b0, 2'd0, '0);
    step('0, 1'b1, 2'd3, KEY);
    for (int i = 0; i < RST_LEN - 1; i++) step('0, 1'b0, 2'd0, '0);
    chk({31'b0, core_rst_o}, 32'h1, "R11 retrigger extends");
    step('0, 1'b0, 2'd0, '0);
    chk({31'b0, core_rst_o}, 32'h0, "R11 retrigger end");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] e;
      logic w;
      logic [1:0] a;
      logic [31:0] d;
      e = ($urandom % 4 == 0) ? N'($urandom) : '0;
      w = ($urandom % 2) == 1;
      a = 2'($urandom);
      d = $urandom;
      if (a == 2'd3 && ($urandom % 8 == 0)) d = KEY;
      step(e, w, a, d);
      if (!w) chk(rdata_o, exp_rd(a), "R1 R2 R4 random read");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule